// File: doc/BRIEF.md
# PHY PLL Bring-Up Sequencer

This block powers up a multi-lane serial PHY when it gets a power-on request. It releases the PHY reset, points the configuration address at the PLL-lock register and takes lane A out of idle. It then waits for the PLL to lock. Next it makes two strobed configuration writes and waits for the PLL output-active status to drop. Last, it points the address at the lock register again and waits for the PLL to relock. Each of the three waits reads the status only on a fixed polling grid and has its own timeout. A timeout puts the PHY back into reset and ends the attempt with an error code that names the wait that failed.

A power-off request can arrive at any time. It sets lane A to idle, asserts the PHY reset and cancels any bring-up in progress. Every time is counted in clock cycles, from a cycles-per-microsecond parameter multiplied by microsecond parameters. The default timeout is 20 ms and the default polling interval is 50 µs. A bench can shrink these values.

Top module: `phy_pll_bringup`

## Requirements
- R1: After reset, phyReset=1, laneIdle=1, cfgStrobe=0, seqDone=0, errCode=0, cfgAddr=0 and cfgData=0.
- R2: A power-on request while powered off (or after an error) takes effect at the next clock edge. At that edge phyReset drops to 0, laneIdle drops to 0, cfgAddr becomes 0x10 and errCode clears to 0.
- R3: In the first lock wait, lockStatus is sampled at the first clock edge after the wait is entered and then every POLL_US*CYC_PER_US cycles. The first sample that reads 1 ends the wait.
- R4: Two configuration writes follow lock. At the edge where lock is seen, cfgAddr=0x10 and cfgData=0x8. cfgStrobe is 1 from CYC_PER_US to 2*CYC_PER_US cycles after that edge. At 2*CYC_PER_US cycles, cfgAddr becomes 0x12. cfgStrobe is 1 again from 3*CYC_PER_US to 4*CYC_PER_US cycles. cfgAddr and cfgData do not change while cfgStrobe is 1.
- R5: The output wait starts 4*CYC_PER_US cycles after lock. It uses the same sampling grid and ends at the first sample where outActiveStatus reads 0. At that edge cfgAddr returns to 0x10.
- R6: The relock wait ends at the first sample where lockStatus reads 1. At that edge seqDone pulses for exactly one cycle, errCode=0, and the PHY stays out of reset with lane A active.
- R7: A wait times out at a sample that fails its condition once at least TIMEOUT_US*CYC_PER_US cycles have passed since the wait was entered. At that edge phyReset=1 and seqDone pulses once. errCode becomes 1 for the first lock wait, 2 for the output wait and 3 for the relock wait. laneIdle keeps its value.
- R8: A power-off request in any state sets laneIdle=1, phyReset=1 and cfgStrobe=0 at the next edge and cancels any bring-up. It wins over a power-on request in the same cycle.
- R9: A power-on request is ignored while bring-up is in progress or the PHY is already up.
- R10: The status inputs are ignored during the configuration writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| powerOnReq | input | 1 | Request to bring the PHY up |
| powerOffReq | input | 1 | Request to shut the PHY down; has priority |
| lockStatus | input | 1 | PLL locked (status bit 9) |
| outActiveStatus | input | 1 | PLL output active (status bit 10) |
| phyReset | output | 1 | PHY reset, 1 = held in reset |
| laneIdle | output | 1 | Lane A idle control, 1 = idle |
| cfgAddr | output | ADDR_W | Configuration port address |
| cfgData | output | DATA_W | Configuration port data |
| cfgStrobe | output | 1 | Configuration write strobe |
| seqDone | output | 1 | One-cycle pulse when bring-up ends, whether it succeeds or fails |
| errCode | output | 2 | 0 ok, 1 lock timeout, 2 output-wait timeout, 3 relock timeout |

## Verification
Every output is registered. A request or a status sample therefore shows up at the ports at the clock edge that consumes it, which is one cycle after the request is driven. Configuration strobe edges land at exact multiples of CYC_PER_US after the edge that detects lock. Wait results land only on the polling grid, counted from the edge after the wait is entered. The bench's behavioural model advances on the same edges using its own integer phase counters. The bench compares every output against the model at each falling edge, so a result that arrives a cycle early or late is reported. Status pulses that fall between samples, and status toggles during the configuration writes, test that sampling happens only on the grid.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

  typedef enum logic [2:0] {
    ST_OFF,
    ST_WAIT_LOCK,
    ST_CFG_SETUP,
    ST_CFG_HIGH,
    ST_WAIT_OUT,
    ST_WAIT_RELOCK,
    ST_UP
  } seqState_t;

  localparam logic [1:0] ERR_NONE   = 2'd0;
  localparam logic [1:0] ERR_LOCK   = 2'd1;
  localparam logic [1:0] ERR_OUT    = 2'd2;
  localparam logic [1:0] ERR_RELOCK = 2'd3;

  // Control-to-datapath strobes, one cycle each
  typedef struct packed {
    logic       powerUp;    // release reset, lane active, select lock address
    logic       powerDown;  // idle lane, assert reset, drop strobe
    logic       loadCfg;    // drive a config address/data pair
    logic       cfgSel;     // 0 = first write, 1 = second write
    logic       strobeOn;
    logic       strobeOff;
    logic       selLock;    // reselect lock address
    logic       clrTimers;  // restart microsecond, poll and elapsed counters
    logic       finish;     // end of bring-up, report errVal
    logic [1:0] errVal;
  } seqCmd_t;

endpackage

// File: rtl/phy_seq_ctrl.sv
module phy_seq_ctrl
  import phy_seq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    powerOnReq,
  input  logic    powerOffReq,
  input  logic    lockSeen,
  input  logic    outSeen,
  input  logic    pollTick,
  input  logic    timedOut,
  input  logic    usTick,
  output seqCmd_t cmd
);

  seqState_t state, stateNxt;
  logic      wrIdx, wrIdxNxt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_OFF;
      wrIdx <= 1'b0;
    end else begin
      state <= stateNxt;
      wrIdx <= wrIdxNxt;
    end
  end

  always_comb begin
    cmd      = '0;
    stateNxt = state;
    wrIdxNxt = wrIdx;
    if (powerOffReq) begin
      cmd.powerDown = 1'b1;
      stateNxt      = ST_OFF;
    end else begin
      unique case (state)
        ST_OFF: begin
          if (powerOnReq) begin
            cmd.powerUp   = 1'b1;
            cmd.clrTimers = 1'b1;
            stateNxt      = ST_WAIT_LOCK;
          end
        end
        ST_WAIT_LOCK: begin
          if (pollTick) begin
            if (lockSeen) begin
              cmd.loadCfg   = 1'b1;
              cmd.cfgSel    = 1'b0;
              cmd.clrTimers = 1'b1;
              wrIdxNxt      = 1'b0;
              stateNxt      = ST_CFG_SETUP;
            end else if (timedOut) begin
              cmd.finish = 1'b1;
              cmd.errVal = ERR_LOCK;
              stateNxt   = ST_OFF;
            end
          end
        end
        ST_CFG_SETUP: begin
          if (usTick) begin
            cmd.strobeOn = 1'b1;
            stateNxt     = ST_CFG_HIGH;
          end
        end
        ST_CFG_HIGH: begin
          if (usTick) begin
            cmd.strobeOff = 1'b1;
            if (!wrIdx) begin
              cmd.loadCfg = 1'b1;
              cmd.cfgSel  = 1'b1;
              wrIdxNxt    = 1'b1;
              stateNxt    = ST_CFG_SETUP;
            end else begin
              cmd.clrTimers = 1'b1;
              stateNxt      = ST_WAIT_OUT;
            end
          end
        end
        ST_WAIT_OUT: begin
          if (pollTick) begin
            if (!outSeen) begin
              cmd.selLock   = 1'b1;
              cmd.clrTimers = 1'b1;
              stateNxt      = ST_WAIT_RELOCK;
            end else if (timedOut) begin
              cmd.finish = 1'b1;
              cmd.errVal = ERR_OUT;
              stateNxt   = ST_OFF;
            end
          end
        end
        ST_WAIT_RELOCK: begin
          if (pollTick) begin
            if (lockSeen) begin
              cmd.finish = 1'b1;
              cmd.errVal = ERR_NONE;
              stateNxt   = ST_UP;
            end else if (timedOut) begin
              cmd.finish = 1'b1;
              cmd.errVal = ERR_RELOCK;
              stateNxt   = ST_OFF;
            end
          end
        end
        ST_UP: stateNxt = ST_UP;
        default: stateNxt = ST_OFF;
      endcase
    end
  end

  p_off_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    powerOffReq |=> (state == ST_OFF));

  p_up_holds_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_UP && !powerOffReq) |=> (state == ST_UP));

endmodule

// File: rtl/phy_seq_datapath.sv
module phy_seq_datapath
  import phy_seq_pkg::*;
#(
  parameter int CYC_PER_US = 100,
  parameter int TIMEOUT_US = 20000,
  parameter int POLL_US    = 50,
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 4,
  parameter logic [ADDR_W-1:0] LOCK_ADDR  = 6'h10,
  parameter logic [ADDR_W-1:0] CFG_ADDR_A = 6'h10,
  parameter logic [ADDR_W-1:0] CFG_ADDR_B = 6'h12,
  parameter logic [DATA_W-1:0] CFG_DATA   = 4'h8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCmd_t           cmd,
  output logic              phyReset,
  output logic              laneIdle,
  output logic [ADDR_W-1:0] cfgAddr,
  output logic [DATA_W-1:0] cfgData,
  output logic              cfgStrobe,
  output logic              seqDone,
  output logic [1:0]        errCode,
  output logic              pollTick,
  output logic              timedOut,
  output logic              usTick
);

  localparam int US_CYC   = CYC_PER_US;
  localparam int POLL_CYC = POLL_US * CYC_PER_US;
  localparam int TO_CYC   = TIMEOUT_US * CYC_PER_US;
  localparam int US_W     = $clog2(US_CYC + 1);
  localparam int PO_W     = $clog2(POLL_CYC + 1);
  localparam int EL_W     = $clog2(TO_CYC + 1);

  logic [US_W-1:0] usCnt;
  logic [PO_W-1:0] pollCnt;
  logic [EL_W-1:0] elapsed;

  assign usTick   = (usCnt == US_W'(US_CYC - 1));
  assign pollTick = (pollCnt == '0);
  assign timedOut = (elapsed >= EL_W'(TO_CYC));

  // Timers
  always_ff @(posedge clk) begin
    if (!rstN || cmd.clrTimers) begin
      usCnt   <= '0;
      pollCnt <= '0;
      elapsed <= '0;
    end else begin
      usCnt   <= usTick ? '0 : usCnt + 1'b1;
      pollCnt <= (pollCnt == PO_W'(POLL_CYC - 1)) ? '0 : pollCnt + 1'b1;
      if (!timedOut) elapsed <= elapsed + 1'b1;
    end
  end

  // PHY-facing registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      phyReset  <= 1'b1;
      laneIdle  <= 1'b1;
      cfgAddr   <= '0;
      cfgData   <= '0;
      cfgStrobe <= 1'b0;
      seqDone   <= 1'b0;
      errCode   <= ERR_NONE;
    end else begin
      seqDone <= 1'b0;
      if (cmd.powerDown) begin
        phyReset  <= 1'b1;
        laneIdle  <= 1'b1;
        cfgStrobe <= 1'b0;
      end else begin
        if (cmd.powerUp) begin
          phyReset <= 1'b0;
          laneIdle <= 1'b0;
          cfgAddr  <= LOCK_ADDR;
          errCode  <= ERR_NONE;
        end
        if (cmd.loadCfg) begin
          cfgAddr <= cmd.cfgSel ? CFG_ADDR_B : CFG_ADDR_A;
          cfgData <= CFG_DATA;
        end
        if (cmd.selLock)   cfgAddr   <= LOCK_ADDR;
        if (cmd.strobeOn)  cfgStrobe <= 1'b1;
        if (cmd.strobeOff) cfgStrobe <= 1'b0;
        if (cmd.finish) begin
          seqDone <= 1'b1;
          errCode <= cmd.errVal;
          if (cmd.errVal != ERR_NONE) phyReset <= 1'b1;
        end
      end
    end
  end

  p_strobe_live_phy_r4: assert property (@(posedge clk) disable iff (!rstN)
    cfgStrobe |-> !phyReset);

  p_addr_steady_r4: assert property (@(posedge clk) disable iff (!rstN)
    cfgStrobe |-> ($stable(cfgAddr) && $stable(cfgData)));

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    seqDone |=> !seqDone);

  p_err_in_reset_r7: assert property (@(posedge clk) disable iff (!rstN)
    (errCode != ERR_NONE) |-> phyReset);

endmodule

// File: rtl/phy_pll_bringup.sv
module phy_pll_bringup
  import phy_seq_pkg::*;
#(
  parameter int CYC_PER_US = 100,
  parameter int TIMEOUT_US = 20000,
  parameter int POLL_US    = 50,
  parameter int ADDR_W     = 6,
  parameter int DATA_W     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              powerOnReq,
  input  logic              powerOffReq,
  input  logic              lockStatus,
  input  logic              outActiveStatus,
  output logic              phyReset,
  output logic              laneIdle,
  output logic [ADDR_W-1:0] cfgAddr,
  output logic [DATA_W-1:0] cfgData,
  output logic              cfgStrobe,
  output logic              seqDone,
  output logic [1:0]        errCode
);

  seqCmd_t cmd;
  logic    pollTick, timedOut, usTick;

  phy_seq_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .powerOnReq (powerOnReq),
    .powerOffReq(powerOffReq),
    .lockSeen   (lockStatus),
    .outSeen    (outActiveStatus),
    .pollTick   (pollTick),
    .timedOut   (timedOut),
    .usTick     (usTick),
    .cmd        (cmd)
  );

  phy_seq_datapath #(
    .CYC_PER_US(CYC_PER_US),
    .TIMEOUT_US(TIMEOUT_US),
    .POLL_US   (POLL_US),
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .LOCK_ADDR (ADDR_W'(6'h10)),
    .CFG_ADDR_A(ADDR_W'(6'h10)),
    .CFG_ADDR_B(ADDR_W'(6'h12)),
    .CFG_DATA  (DATA_W'(4'h8))
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .cmd      (cmd),
    .phyReset (phyReset),
    .laneIdle (laneIdle),
    .cfgAddr  (cfgAddr),
    .cfgData  (cfgData),
    .cfgStrobe(cfgStrobe),
    .seqDone  (seqDone),
    .errCode  (errCode),
    .pollTick (pollTick),
    .timedOut (timedOut),
    .usTick   (usTick)
  );

  p_poweroff_idles_r8: assert property (@(posedge clk) disable iff (!rstN)
    powerOffReq |=> (phyReset && laneIdle && !cfgStrobe));

  p_up_live_r6: assert property (@(posedge clk) disable iff (!rstN)
    (seqDone && errCode == ERR_NONE) |-> (!phyReset && !laneIdle));

endmodule

// File: tb/tb_phy_pll_bringup.sv
module tb_phy_pll_bringup;

  localparam int CPU  = 2;
  localparam int TOU  = 40;
  localparam int PU   = 5;
  localparam int US   = CPU;
  localparam int POLL = PU * CPU;
  localparam int TO   = TOU * CPU;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic onReq = 1'b0, offReq = 1'b0;
  logic lockIn = 1'b0, outIn = 1'b1;
  logic phyReset, laneIdle, cfgStrobe, seqDone;
  logic [5:0] cfgAddr;
  logic [3:0] cfgData;
  logic [1:0] errCode;

  int tests = 0, fails = 0, cyc = 0;
  string curTag = "R1";

  always #5 clk = ~clk;

  phy_pll_bringup #(.CYC_PER_US(CPU), .TIMEOUT_US(TOU), .POLL_US(PU)) dut (
    .clk(clk), .rstN(rstN), .powerOnReq(onReq), .powerOffReq(offReq),
    .lockStatus(lockIn), .outActiveStatus(outIn),
    .phyReset(phyReset), .laneIdle(laneIdle), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .cfgStrobe(cfgStrobe), .seqDone(seqDone),
    .errCode(errCode)
  );

  // Behavioural reference: phase 0 off, 1 lock wait, 2 config, 3 output wait,
  // 4 relock wait, 5 up
  int mState = 0, since = 0, cfgT = 0, n = 0;
  logic eRst = 1, eIdle = 1, eStb = 0, eDone = 0;
  logic [5:0] eAddr = 0;
  logic [3:0] eData = 0;
  logic [1:0] eErr = 0;

  function automatic logic waitMet(int ph, logic lk, logic oa);
    return (ph == 3) ? !oa : lk;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mState <= 0; eRst <= 1; eIdle <= 1; eStb <= 0; eDone <= 0;
      eAddr <= 0; eData <= 0; eErr <= 0;
    end else begin
      eDone <= 0;
      if (offReq) begin
        eRst <= 1; eIdle <= 1; eStb <= 0; mState <= 0;
      end else begin
        case (mState)
          0: if (onReq) begin
               eRst <= 0; eIdle <= 0; eAddr <= 6'h10; eErr <= 0;
               mState <= 1; since <= 0;
             end
          1, 3, 4: begin
            if (since % POLL == 0 && waitMet(mState, lockIn, outIn)) begin
              if (mState == 1) begin
                mState <= 2; cfgT <= 0; eAddr <= 6'h10; eData <= 4'h8;
              end else if (mState == 3) begin
                mState <= 4; since <= 0; eAddr <= 6'h10;
              end else begin
                mState <= 5; eDone <= 1; eErr <= 0;
              end
            end else if (since % POLL == 0 && since >= TO) begin
              eRst <= 1; eDone <= 1; mState <= 0;
              eErr <= (mState == 1) ? 2'd1 : (mState == 3) ? 2'd2 : 2'd3;
            end else begin
              since <= since + 1;
            end
          end
          2: begin
            n = cfgT + 1;
            cfgT <= n;
            eStb <= ((n >= US && n < 2*US) || (n >= 3*US && n < 4*US));
            if (n == 2*US) eAddr <= 6'h12;
            if (n == 4*US) begin mState <= 3; since <= 0; end
          end
          default: ;
        endcase
      end
    end
  end

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      tests++;
      if ({phyReset, laneIdle, cfgAddr, cfgData, cfgStrobe, seqDone, errCode} !==
          {eRst, eIdle, eAddr, eData, eStb, eDone, eErr}) begin
        fails++;
        $display("FAIL %s cycle %0d: rst/idle/addr/data/stb/done/err actual %b/%b/%h/%h/%b/%b/%0d expected %b/%b/%h/%h/%b/%b/%0d",
                 curTag, cyc, phyReset, laneIdle, cfgAddr, cfgData, cfgStrobe, seqDone, errCode,
                 eRst, eIdle, eAddr, eData, eStb, eDone, eErr);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL %s watchdog: actual hang, expected completion", curTag);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s explicit check: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic pulseOn();
    @(negedge clk) onReq = 1'b1;
    @(negedge clk) onReq = 1'b0;
  endtask

  task automatic pulseOff();
    @(negedge clk) offReq = 1'b1;
    @(negedge clk) offReq = 1'b0;
  endtask

  task automatic waitPhase(input int ph);
    int k = 0;
    while (mState != ph && k < 2000) begin @(negedge clk); k++; end
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    curTag = "R1";
    chk(phyReset && laneIdle && !cfgStrobe && !seqDone && errCode == 0 && cfgAddr == 0,
        "R1", {phyReset, laneIdle}, 3);

    // Full bring-up with status toggling during the writes
    curTag = "R2";
    pulseOn();
    chk(!phyReset && !laneIdle && cfgAddr == 6'h10, "R2", cfgAddr, 16);
    curTag = "R3";
    repeat (23) @(negedge clk);
    lockIn = 1'b1;
    waitPhase(2);
    curTag = "R10";
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); lockIn = ~lockIn; outIn = ~outIn;
    end
    lockIn = 1'b0; outIn = 1'b1;
    curTag = "R4";
    waitPhase(3);
    curTag = "R5";
    repeat (14) @(negedge clk);
    outIn = 1'b0;
    waitPhase(4);
    curTag = "R6";
    repeat (17) @(negedge clk);
    lockIn = 1'b1;
    waitPhase(5);
    chk(errCode == 0 && !phyReset, "R6", errCode, 0);

    // Power-on while up is ignored
    curTag = "R9";
    pulseOn();
    repeat (5) @(negedge clk);
    chk(!phyReset && !laneIdle && cfgAddr == 6'h10, "R9", phyReset, 0);

    curTag = "R8";
    pulseOff();
    chk(phyReset && laneIdle, "R8", {phyReset, laneIdle}, 3);

    // First-wait timeout
    curTag = "R7";
    lockIn = 1'b0; outIn = 1'b1;
    pulseOn();
    waitPhase(0);
    chk(errCode == 1 && phyReset, "R7", errCode, 1);

    // Output-wait timeout
    lockIn = 1'b1;
    pulseOn();
    waitPhase(0);
    chk(errCode == 2 && phyReset && !laneIdle, "R7", errCode, 2);

    // Relock timeout
    pulseOn();
    waitPhase(3);
    lockIn = 1'b0; outIn = 1'b0;
    waitPhase(0);
    chk(errCode == 3 && phyReset, "R7", errCode, 3);

    // Abort during the config writes
    curTag = "R8";
    lockIn = 1'b1; outIn = 1'b1;
    pulseOn();
    waitPhase(2);
    repeat (2) @(negedge clk);
    pulseOff();
    chk(phyReset && laneIdle && !cfgStrobe, "R8", cfgStrobe, 0);
    repeat (20) @(negedge clk);

    // Power-on during a wait is ignored; the timeout keeps its timing
    curTag = "R9";
    lockIn = 1'b0;
    pulseOn();
    repeat (7) @(negedge clk);
    pulseOn();
    waitPhase(0);
    chk(errCode == 1, "R9", errCode, 1);

    // Simultaneous requests: off wins
    curTag = "R8";
    @(negedge clk) begin onReq = 1'b1; offReq = 1'b1; end
    @(negedge clk) begin onReq = 1'b0; offReq = 1'b0; end
    chk(phyReset && laneIdle, "R8", phyReset, 1);
    repeat (5) @(negedge clk);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule